// File: doc/BRIEF.md
# Selectable No-Load Creep Gate

This block sits between a power (or RMS current) sample source and the energy accumulators of a metering datapath. Each valid sample's magnitude is compared against a small threshold derived from the full-scale multiplier output. If the magnitude falls under that threshold, the sample is forced to zero before it reaches the accumulators, so a meter with no real load does not slowly creep forward on noise and offset.

A 2-bit mode field picks the threshold. One code turns detection off, and the other three select levels that halve at each step. The same threshold applies whether the apparent-power sample or an RMS-current sample is routed through the gate.

A sticky no-load status flag records that a below-threshold sample was seen. Software clears it with a write-one-to-clear pulse. When the interrupt enable is set, an interrupt output follows the flag. The valid strobe always passes through unchanged, so downstream timing does not depend on the gating decision.

Top module: `creep_gate`

## Requirements
- R1: With modeSel = 2'b00, detection is off. Every valid sample passes unchanged, gateActive stays 0, and noLoadStatus is never set.
- R2: modeSel = 2'b01, 2'b10 and 2'b11 select thresholds of floor(3*FULL_SCALE/10000), floor(3*FULL_SCALE/20000) and floor(3*FULL_SCALE/40000). These are 2516, 1258 and 629 for the default FULL_SCALE of 8388607. A sample whose magnitude is below the selected threshold is gated.
- R3: A sample whose magnitude equals the threshold counts as loaded and passes unchanged.
- R4: A signed power sample is compared by its magnitude, so negative samples are gated or passed exactly like their positive counterparts. When it passes, the sign is kept on the output.
- R5: One cycle after every sampleValid, gatedValid is 1, and it is 0 in cycles that follow no valid input. A gated sample appears on gatedSample as zero.
- R6: gateActive is registered together with gatedSample. It is 1 when the last valid sample was gated and 0 when it passed, and it holds between samples.
- R7: A gated sample sets noLoadStatus one cycle after its valid cycle. The flag stays set until a clear pulse, whatever later samples do.
- R8: A 1 on statusClear clears noLoadStatus at the next edge. If a gated sample arrives in the same cycle, the flag stays set.
- R9: irq is noLoadStatus AND irqEnable, with no added cycle of delay.
- R10: With srcSel = 1, the unsigned rmsSample input is gated against the same threshold instead of powerSample. With srcSel = 0, powerSample is used.
- R11: After reset, gatedValid, gatedSample, gateActive, noLoadStatus and irq are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Threshold select: 00 off, 01/10/11 descending levels |
| srcSel | input | 1 | 0 = signed power sample, 1 = RMS-current sample |
| sampleValid | input | 1 | Input sample strobe |
| powerSample | input | SAMPLE_W | Signed power sample |
| rmsSample | input | SAMPLE_W | Unsigned RMS-current sample |
| irqEnable | input | 1 | Interrupt enable mask for the no-load flag |
| statusClear | input | 1 | Write-one-to-clear pulse for the no-load flag |
| gatedValid | output | 1 | Delayed copy of sampleValid |
| gatedSample | output | SAMPLE_W | Selected sample, or zero when gated |
| gateActive | output | 1 | Last valid sample was gated |
| noLoadStatus | output | 1 | Sticky no-load flag |
| irq | output | 1 | Interrupt request |

## Verification
If the mode decode or the comparator is wrong, it shows on the very next gatedValid cycle: a nonzero gatedSample appears with gateActive set, or a sample at the boundary is zeroed. The vectors therefore sit exactly on and one below each threshold, for both signs and for both sources. If the flag logic is wrong, noLoadStatus drops on its own, fails to set one cycle after a gated sample, or loses the race against a simultaneous clear. The interrupt is checked in the same cycle the enable changes.

// File: rtl/creep_gate_pkg.sv
package creep_gate_pkg;

  localparam int unsigned LEVELS = 3;

  // Strobes and decoded settings passed from control to datapath
  typedef struct packed {
    logic              detectEn;
    logic [LEVELS-1:0] levelHot;
    logic              useRms;
    logic              sampleStrobe;
  } gate_ctrl_t;

  // Threshold = floor(3 * fullScale / divisor)
  function automatic logic [63:0] thresholdFor(input logic [63:0] fullScale,
                                               input logic [63:0] divisor);
    return (fullScale * 64'd3) / divisor;
  endfunction

endpackage

// File: rtl/creep_gate_ctrl.sv
module creep_gate_ctrl
  import creep_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       srcSel,
  input  logic       sampleValid,
  input  logic       belowThr,
  input  logic       irqEnable,
  input  logic       statusClear,
  output gate_ctrl_t ctrl,
  output logic       noLoadStatus,
  output logic       irq
);

  logic statusQ;
  logic setReq;

  // Mode decode: 00 disables, others pick one level as one-hot
  always_comb begin
    ctrl.detectEn     = (modeSel != 2'b00);
    ctrl.levelHot     = '0;
    ctrl.useRms       = srcSel;
    ctrl.sampleStrobe = sampleValid;
    case (modeSel)
      2'b01:   ctrl.levelHot = 3'b001;
      2'b10:   ctrl.levelHot = 3'b010;
      2'b11:   ctrl.levelHot = 3'b100;
      default: ctrl.levelHot = 3'b000;
    endcase
  end

  assign setReq = sampleValid && belowThr;

  // Sticky flag; a fresh set wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            statusQ <= 1'b0;
    else if (setReq)      statusQ <= 1'b1;
    else if (statusClear) statusQ <= 1'b0;
  end

  assign noLoadStatus = statusQ;
  assign irq          = statusQ && irqEnable;

endmodule

// File: rtl/creep_gate_datapath.sv
module creep_gate_datapath
  import creep_gate_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = 24,
  parameter logic [63:0] FULL_SCALE = 64'd8388607
) (
  input  logic                clk,
  input  logic                rstN,
  input  gate_ctrl_t          ctrl,
  input  logic [SAMPLE_W-1:0] powerSample,
  input  logic [SAMPLE_W-1:0] rmsSample,
  output logic                belowThr,
  output logic                gatedValid,
  output logic [SAMPLE_W-1:0] gatedSample,
  output logic                gateActive
);

  logic [SAMPLE_W-1:0] powerMag;
  logic [SAMPLE_W-1:0] selRaw;
  logic [SAMPLE_W-1:0] selMag;
  logic [LEVELS-1:0]   belowVec;

  // Two's-complement magnitude; the most negative value maps to 2^(W-1)
  assign powerMag = powerSample[SAMPLE_W-1] ? (~powerSample + 1'b1) : powerSample;
  assign selRaw   = ctrl.useRms ? rmsSample : powerSample;
  assign selMag   = ctrl.useRms ? rmsSample : powerMag;

  // One comparator per level; each level halves the one before it
  for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_level
    localparam logic [63:0] THR = thresholdFor(FULL_SCALE, 64'd10000 << lvl);
    assign belowVec[lvl] = ({{(64-SAMPLE_W){1'b0}}, selMag} < THR);
  end

  assign belowThr = ctrl.detectEn && |(belowVec & ctrl.levelHot);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gatedValid  <= 1'b0;
      gatedSample <= '0;
      gateActive  <= 1'b0;
    end else begin
      gatedValid <= ctrl.sampleStrobe;
      if (ctrl.sampleStrobe) begin
        gatedSample <= belowThr ? '0 : selRaw;
        gateActive  <= belowThr;
      end
    end
  end

endmodule

// File: rtl/creep_gate.sv
module creep_gate #(
  parameter int unsigned SAMPLE_W   = 24,
  parameter logic [63:0] FULL_SCALE = 64'd8388607
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          modeSel,
  input  logic                srcSel,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] powerSample,
  input  logic [SAMPLE_W-1:0] rmsSample,
  input  logic                irqEnable,
  input  logic                statusClear,
  output logic                gatedValid,
  output logic [SAMPLE_W-1:0] gatedSample,
  output logic                gateActive,
  output logic                noLoadStatus,
  output logic                irq
);

  creep_gate_pkg::gate_ctrl_t ctrl;
  logic belowThr;

  creep_gate_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .modeSel      (modeSel),
    .srcSel       (srcSel),
    .sampleValid  (sampleValid),
    .belowThr     (belowThr),
    .irqEnable    (irqEnable),
    .statusClear  (statusClear),
    .ctrl         (ctrl),
    .noLoadStatus (noLoadStatus),
    .irq          (irq)
  );

  creep_gate_datapath #(
    .SAMPLE_W   (SAMPLE_W),
    .FULL_SCALE (FULL_SCALE)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .powerSample (powerSample),
    .rmsSample   (rmsSample),
    .belowThr    (belowThr),
    .gatedValid  (gatedValid),
    .gatedSample (gatedSample),
    .gateActive  (gateActive)
  );

endmodule

// File: rtl/creep_gate_checker.sv
module creep_gate_checker #(
  parameter int unsigned SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rstN,
  input logic [1:0]          modeSel,
  input logic                sampleValid,
  input logic                irqEnable,
  input logic                statusClear,
  input logic                gatedValid,
  input logic [SAMPLE_W-1:0] gatedSample,
  input logic                gateActive,
  input logic                noLoadStatus,
  input logic                irq
);

  assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> gatedValid);

  assert_no_valid_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> !gatedValid);

  assert_gated_is_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (gatedValid && gateActive) |-> (gatedSample == '0));

  assert_disabled_passes_R1: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && modeSel == 2'b00) |=> !gateActive);

  assert_gate_sets_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (gatedValid && gateActive) |-> noLoadStatus);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (noLoadStatus && !statusClear) |=> noLoadStatus);

  assert_flag_rise_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(noLoadStatus) |-> (gatedValid && gateActive));

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!noLoadStatus || !irqEnable) |-> !irq);

  assert_irq_raised_R9: assert property (@(posedge clk) disable iff (!rstN)
    (noLoadStatus && irqEnable) |-> irq);

endmodule

bind creep_gate creep_gate_checker #(.SAMPLE_W(SAMPLE_W)) u_checker (.*);

// File: tb/creep_gate_test.sv
module creep_gate_test;

  localparam int unsigned SAMPLE_W = 24;
  localparam time         CLK_PERIOD = 10ns;
  localparam logic [63:0] FS = 64'd8388607;
  localparam int          THR1 = int'((FS * 3) / 10000);
  localparam int          THR2 = int'((FS * 3) / 20000);
  localparam int          THR3 = int'((FS * 3) / 40000);

  typedef struct packed {
    logic [1:0]          mode;
    logic                src;
    logic [SAMPLE_W-1:0] pwr;
    logic [SAMPLE_W-1:0] rms;
    logic [SAMPLE_W-1:0] expOut;
    logic                expGate;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 1'b0, 24'(THR1),     24'd0,        24'(THR1),   1'b0}, // R3 on level 1
    '{2'b01, 1'b0, 24'(THR1-1),   24'd0,        24'd0,       1'b1}, // R2
    '{2'b01, 1'b0, 24'(-THR1),    24'd0,        24'(-THR1),  1'b0}, // R4
    '{2'b01, 1'b0, 24'(-(THR1-1)),24'd0,        24'd0,       1'b1}, // R4
    '{2'b10, 1'b0, 24'(THR2),     24'd0,        24'(THR2),   1'b0}, // R3 on level 2
    '{2'b10, 1'b0, 24'(THR2-1),   24'd0,        24'd0,       1'b1}, // R2
    '{2'b11, 1'b0, 24'(THR3),     24'd0,        24'(THR3),   1'b0}, // R3 on level 3
    '{2'b11, 1'b0, 24'(THR3-1),   24'd0,        24'd0,       1'b1}, // R2
    '{2'b11, 1'b0, 24'(-THR3),    24'd0,        24'(-THR3),  1'b0}, // R4
    '{2'b00, 1'b0, 24'd0,         24'd0,        24'd0,       1'b0}, // R1
    '{2'b00, 1'b0, 24'd5,         24'd0,        24'd5,       1'b0}, // R1
    '{2'b01, 1'b1, 24'd0,         24'(THR1-1),  24'd0,       1'b1}, // R10
    '{2'b01, 1'b1, 24'd0,         24'd3000,     24'd3000,    1'b0}, // R10
    '{2'b01, 1'b1, 24'(THR1+100), 24'd5,        24'd0,       1'b1}  // R10 source ignored
  };

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [1:0]          modeSel = 2'b00;
  logic                srcSel = 1'b0;
  logic                sampleValid = 1'b0;
  logic [SAMPLE_W-1:0] powerSample = '0;
  logic [SAMPLE_W-1:0] rmsSample = '0;
  logic                irqEnable = 1'b0;
  logic                statusClear = 1'b0;
  logic                gatedValid;
  logic [SAMPLE_W-1:0] gatedSample;
  logic                gateActive;
  logic                noLoadStatus;
  logic                irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  creep_gate #(.SAMPLE_W(SAMPLE_W), .FULL_SCALE(FS)) uut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive one sample at a falling edge; return at the next falling edge
  task automatic sendSample(input logic [1:0] m, input logic s,
                            input logic [SAMPLE_W-1:0] p, input logic [SAMPLE_W-1:0] r,
                            input logic clr);
    modeSel = m; srcSel = s; powerSample = p; rmsSample = r;
    sampleValid = 1'b1; statusClear = clr;
    @(negedge clk);
    sampleValid = 1'b0; statusClear = 1'b0;
  endtask

  task automatic pulseClear();
    statusClear = 1'b1;
    @(negedge clk);
    statusClear = 1'b0;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 gatedValid", 64'(gatedValid), 64'd0);
    check("R11 gatedSample", 64'(gatedSample), 64'd0);
    check("R11 gateActive", 64'(gateActive), 64'd0);
    check("R11 noLoadStatus", 64'(noLoadStatus), 64'd0);
    check("R11 irq", 64'(irq), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Vector table walk: R1 R2 R3 R4 R5 R6 R10
    for (int i = 0; i < NV; i++) begin
      sendSample(VECS[i].mode, VECS[i].src, VECS[i].pwr, VECS[i].rms, 1'b0);
      check($sformatf("R5 valid vec %0d", i), 64'(gatedValid), 64'd1);
      check($sformatf("R2 sample vec %0d", i), 64'(gatedSample), 64'(VECS[i].expOut));
      check($sformatf("R6 gate vec %0d", i), 64'(gateActive), 64'(VECS[i].expGate));
    end

    // R5: no valid in, no valid out; R6: gateActive holds
    @(negedge clk);
    check("R5 idle valid", 64'(gatedValid), 64'd0);
    check("R6 gate holds", 64'(gateActive), 64'd1);

    // Flag/interrupt sequence
    pulseClear();
    check("R8 cleared", 64'(noLoadStatus), 64'd0);
    sendSample(2'b01, 1'b0, 24'(THR1 + 10), '0, 1'b0);
    check("R7 loaded no set", 64'(noLoadStatus), 64'd0);
    sendSample(2'b01, 1'b0, 24'd7, '0, 1'b0);
    check("R7 set on gate", 64'(noLoadStatus), 64'd1);
    check("R9 masked", 64'(irq), 64'd0);
    irqEnable = 1'b1; #1;
    check("R9 enabled", 64'(irq), 64'd1);
    sendSample(2'b01, 1'b0, 24'(THR1 + 10), '0, 1'b0);
    check("R7 sticky", 64'(noLoadStatus), 64'd1);
    repeat (3) @(negedge clk);
    check("R7 sticky idle", 64'(noLoadStatus), 64'd1);
    pulseClear();
    check("R8 clear", 64'(noLoadStatus), 64'd0);
    check("R9 irq drops", 64'(irq), 64'd0);
    sendSample(2'b11, 1'b0, 24'd1, '0, 1'b1);
    check("R8 set beats clear", 64'(noLoadStatus), 64'd1);
    pulseClear();
    sendSample(2'b00, 1'b0, 24'd1, '0, 1'b0);
    check("R1 no flag when off", 64'(noLoadStatus), 64'd0);
    check("R1 no gate when off", 64'(gateActive), 64'd0);
    check("R1 passes", 64'(gatedSample), 64'd1);
    check("R9 idle irq", 64'(irq), 64'd0);

    // R11: reset in mid-run
    sendSample(2'b01, 1'b0, 24'd1, '0, 1'b0);
    rstN = 1'b0; #1;
    check("R11 async status", 64'(noLoadStatus), 64'd0);
    check("R11 async valid", 64'(gatedValid), 64'd0);
    finishRun();
  end

endmodule